// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block sequences a small microcontroller into and out of its low-power sleep state. When the CPU executes its sleep instruction, it raises a single-cycle request. If both shared pins are already configured as inputs, the controller drops the clock enables of the CPU, random-number-generator and watchdog domains on the next edge. It also issues a one-cycle strobe that returns the nonvolatile-memory control registers to their initial values. All other state is untouched, because only the clock enables are removed.

While asleep, the controller switches the two shared port pins into interrupt-input mode. It watches both pins through a synchronizer and a short low-level filter. A low level that persists on either pin ends sleep: the clock enables return on the next cycle, together with a one-cycle wake interrupt to the CPU. An asynchronous reset also ends sleep at any time and raises the memory-control initialise strobe.

A request made while either direction bit still selects output is refused. In that case the controller stays awake and raises a sticky rejection flag.

Top module: `pd_sleep_ctrl`

## Requirements
- R1: While `rstN` is low and up to the first clock edge after it rises, `nvmCtlInit` is 1 and all three clock enables are 1. After that first edge, `nvmCtlInit`, `pinIrqMode`, `wakeIrq` and `sleepRejected` are all 0.
- R2: A `sleepReq` pulse while awake, with `dirBitA` = 0 and `dirBitB` = 0, makes `cpuClkEn`, `rngClkEn` and `wdtClkEn` go to 0 and `pinIrqMode` go to 1 at the next clock edge.
- R3: Entering sleep raises `nvmCtlInit` for exactly one cycle, in the first sleeping cycle.
- R4: A `sleepReq` while `dirBitA` or `dirBitB` is 1 leaves all clock enables at 1, does not pulse `nvmCtlInit`, and sets `sleepRejected` at the next edge. `sleepRejected` stays set until a later request is accepted, which clears it.
- R5: While asleep, further `sleepReq` pulses have no effect: the enables stay 0 and `nvmCtlInit` stays 0.
- R6: While asleep, a low level on `irqPinAN` that stays low across consecutive samples restores all three enables at the fourth clock edge after the pin falls. At that same edge `pinIrqMode` drops and `wakeIrq` is 1 for exactly one cycle.
- R7: A low level on a pin that lasts only one clock cycle does not end sleep.
- R8: A sustained low level on `irqPinBN` alone ends sleep with the same timing as R6.
- R9: Asserting `rstN` low during sleep immediately restores the enables, clears `pinIrqMode` and raises `nvmCtlInit`, as in R1.
- R10: While awake, low levels on the pins never produce `wakeIrq` and never change the enables.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sleepReq | input | 1 | One-cycle pulse from the CPU on sleep instruction |
| irqPinAN | input | 1 | Shared pin A level, active-low wake interrupt in sleep |
| irqPinBN | input | 1 | Shared pin B level, active-low wake interrupt in sleep |
| dirBitA | input | 1 | Direction bit for pin A (1 = output) |
| dirBitB | input | 1 | Direction bit for pin B (1 = output) |
| cpuClkEn | output | 1 | CPU clock enable |
| rngClkEn | output | 1 | Random-number-generator clock enable |
| wdtClkEn | output | 1 | Watchdog clock enable |
| pinIrqMode | output | 1 | Forces both shared pins into interrupt-input mode |
| nvmCtlInit | output | 1 | Initialise strobe for nonvolatile-memory control registers |
| wakeIrq | output | 1 | One-cycle wake interrupt to the CPU |
| sleepRejected | output | 1 | Sticky flag: last sleep request refused |

## Verification
The assertions check several properties on every cycle:
- the three enables always move together and stay opposite to the pin interrupt mode;
- every drop of the enables comes with the initialise strobe;
- the strobe and the wake interrupt never last more than one cycle;
- a refused request never lets the enables fall;
- a wake interrupt only follows a sleeping cycle.

Only the bench's scenarios can show the exact four-edge wake latency, the rejection of a one-cycle glitch, and wake from the second pin. They also show the clearing of the rejection flag by a later accepted request and the strobe seen across a reset taken during sleep. Each of these needs a specific pin or request history.

// File: rtl/pd_sleep_pkg.sv
package pd_sleep_pkg;

  typedef enum logic {
    PS_AWAKE  = 1'b0,
    PS_ASLEEP = 1'b1
  } pwrState_t;

  // Strobes from control to datapath, valid for one cycle each
  typedef struct packed {
    logic enterSleep;
    logic exitSleep;
    logic rejectReq;
  } ctlStrobe_t;

endpackage

// File: rtl/pd_sleep_fsm.sv
module pd_sleep_fsm
  import pd_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       dirBlock,
  input  logic       wakeSeen,
  output ctlStrobe_t strb,
  output logic       asleep
);

  pwrState_t state, stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      PS_AWAKE: begin
        if (sleepReq) begin
          if (dirBlock) begin
            strb.rejectReq = 1'b1;
          end else begin
            strb.enterSleep = 1'b1;
            stateNext       = PS_ASLEEP;
          end
        end
      end
      PS_ASLEEP: begin
        if (wakeSeen) begin
          strb.exitSleep = 1'b1;
          stateNext      = PS_AWAKE;
        end
      end
      default: stateNext = PS_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PS_AWAKE;
    else       state <= stateNext;
  end

  assign asleep = (state == PS_ASLEEP);

endmodule

// File: rtl/pd_sleep_dp.sv
module pd_sleep_dp
  import pd_sleep_pkg::*;
#(
  parameter int NUM_PINS       = 2,
  parameter int NUM_DOMAINS    = 3,
  parameter int SYNC_STAGES    = 2,
  parameter int FILTER_SAMPLES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_PINS-1:0]    pinN,
  input  ctlStrobe_t             strb,
  output logic                   wakeSeen,
  output logic [NUM_DOMAINS-1:0] clkEn,
  output logic                   nvmInit,
  output logic                   wakePulse,
  output logic                   rejectFlag
);

  localparam int CNT_W = (FILTER_SAMPLES > 1) ? $clog2(FILTER_SAMPLES) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILTER_SAMPLES - 1);

  logic [NUM_PINS-1:0] pinHit;

  // Per-pin synchronizer and consecutive-low filter
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] syncQ;
    logic [CNT_W-1:0]       lowCnt;
    logic                   syncLow;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '1;
      else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinN[p]};
    end

    assign syncLow = ~syncQ[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  lowCnt <= '0;
      else if (!syncLow)          lowCnt <= '0;
      else if (lowCnt != CNT_MAX) lowCnt <= lowCnt + 1'b1;
    end

    assign pinHit[p] = syncLow && (lowCnt == CNT_MAX);
  end

  assign wakeSeen = |pinHit;

  // One enable register per gated domain
  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               clkEn[d] <= 1'b1;
      else if (strb.enterSleep) clkEn[d] <= 1'b0;
      else if (strb.exitSleep)  clkEn[d] <= 1'b1;
    end
  end

  // Initialise strobe: held during reset, pulsed on sleep entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nvmInit <= 1'b1;
    else       nvmInit <= strb.enterSleep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakePulse <= 1'b0;
    else       wakePulse <= strb.exitSleep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rejectFlag <= 1'b0;
    else if (strb.rejectReq)  rejectFlag <= 1'b1;
    else if (strb.enterSleep) rejectFlag <= 1'b0;
  end

endmodule

// File: rtl/pd_sleep_ctrl.sv
module pd_sleep_ctrl
  import pd_sleep_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int FILTER_SAMPLES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReq,
  input  logic irqPinAN,
  input  logic irqPinBN,
  input  logic dirBitA,
  input  logic dirBitB,
  output logic cpuClkEn,
  output logic rngClkEn,
  output logic wdtClkEn,
  output logic pinIrqMode,
  output logic nvmCtlInit,
  output logic wakeIrq,
  output logic sleepRejected
);

  localparam int NUM_PINS    = 2;
  localparam int NUM_DOMAINS = 3;

  ctlStrobe_t             strb;
  logic                   wakeSeen;
  logic                   asleep;
  logic [NUM_DOMAINS-1:0] clkEn;

  pd_sleep_fsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .sleepReq (sleepReq),
    .dirBlock (dirBitA | dirBitB),
    .wakeSeen (wakeSeen),
    .strb     (strb),
    .asleep   (asleep)
  );

  pd_sleep_dp #(
    .NUM_PINS       (NUM_PINS),
    .NUM_DOMAINS    (NUM_DOMAINS),
    .SYNC_STAGES    (SYNC_STAGES),
    .FILTER_SAMPLES (FILTER_SAMPLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pinN       ({irqPinBN, irqPinAN}),
    .strb       (strb),
    .wakeSeen   (wakeSeen),
    .clkEn      (clkEn),
    .nvmInit    (nvmCtlInit),
    .wakePulse  (wakeIrq),
    .rejectFlag (sleepRejected)
  );

  assign cpuClkEn   = clkEn[0];
  assign rngClkEn   = clkEn[1];
  assign wdtClkEn   = clkEn[2];
  assign pinIrqMode = asleep;

endmodule

// File: rtl/pd_sleep_chk.sv
module pd_sleep_chk (
  input logic clk,
  input logic rstN,
  input logic sleepReq,
  input logic dirBitA,
  input logic dirBitB,
  input logic cpuClkEn,
  input logic rngClkEn,
  input logic wdtClkEn,
  input logic pinIrqMode,
  input logic nvmCtlInit,
  input logic wakeIrq
);

  AST_EN_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn == rngClkEn) && (cpuClkEn == wdtClkEn)); // R2

  AST_MODE_OPPOSITE: assert property (@(posedge clk) disable iff (!rstN)
    pinIrqMode != cpuClkEn); // R2

  AST_ENTRY_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuClkEn) |-> nvmCtlInit); // R3

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    nvmCtlInit |=> !nvmCtlInit); // R3

  AST_REJECT_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && cpuClkEn && (dirBitA || dirBitB)) |=> cpuClkEn); // R4

  AST_ASLEEP_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && !cpuClkEn) |=> !nvmCtlInit); // R5

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |=> !wakeIrq); // R6

  AST_WAKE_WITH_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuClkEn) |-> wakeIrq); // R6

  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |-> $past(!cpuClkEn)); // R10

endmodule

bind pd_sleep_ctrl pd_sleep_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sleepReq   (sleepReq),
  .dirBitA    (dirBitA),
  .dirBitB    (dirBitB),
  .cpuClkEn   (cpuClkEn),
  .rngClkEn   (rngClkEn),
  .wdtClkEn   (wdtClkEn),
  .pinIrqMode (pinIrqMode),
  .nvmCtlInit (nvmCtlInit),
  .wakeIrq    (wakeIrq)
);

// File: tb/pd_sleep_ctrl_bench.sv
`timescale 1ns/1ps
module pd_sleep_ctrl_bench;

  logic clk = 1'b0;
  logic rstN, sleepReq, irqPinAN, irqPinBN, dirBitA, dirBitB;
  logic cpuClkEn, rngClkEn, wdtClkEn, pinIrqMode, nvmCtlInit, wakeIrq, sleepRejected;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;

  pd_sleep_ctrl u_pd_sleep_ctrl (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq),
    .irqPinAN(irqPinAN), .irqPinBN(irqPinBN),
    .dirBitA(dirBitA), .dirBitB(dirBitB),
    .cpuClkEn(cpuClkEn), .rngClkEn(rngClkEn), .wdtClkEn(wdtClkEn),
    .pinIrqMode(pinIrqMode), .nvmCtlInit(nvmCtlInit),
    .wakeIrq(wakeIrq), .sleepRejected(sleepRejected)
  );

  task automatic check(input string tag, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // advance n rising edges, then settle at the falling edge
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] en();
    return {1'b0, cpuClkEn, rngClkEn, wdtClkEn};
  endfunction

  task automatic enterSleep(input string tag);
    sleepReq = 1'b1;
    tick(1);
    sleepReq = 1'b0;
    check(tag, "enables after request", en(), 4'b0000);
    check(tag, "pin irq mode", {3'b0, pinIrqMode}, 4'b0001);
  endtask

  task automatic t_reset;
    rstN = 1'b0; sleepReq = 1'b0; irqPinAN = 1'b1; irqPinBN = 1'b1;
    dirBitA = 1'b0; dirBitB = 1'b0;
    tick(2);
    check("R1", "init strobe in reset", {3'b0, nvmCtlInit}, 4'b0001);
    check("R1", "enables in reset", en(), 4'b0111);
    rstN = 1'b1;
    tick(1);
    check("R1", "init strobe after release", {3'b0, nvmCtlInit}, 4'b0000);
    check("R1", "mode/irq/rej after release",
          {1'b0, pinIrqMode, wakeIrq, sleepRejected}, 4'b0000);
    check("R1", "enables after release", en(), 4'b0111);
  endtask

  task automatic t_entry;
    enterSleep("R2");
    check("R3", "strobe first sleep cycle", {3'b0, nvmCtlInit}, 4'b0001);
    tick(1);
    check("R3", "strobe gone", {3'b0, nvmCtlInit}, 4'b0000);
    sleepReq = 1'b1;
    tick(1);
    sleepReq = 1'b0;
    check("R5", "enables stay off", en(), 4'b0000);
    check("R5", "no second strobe", {3'b0, nvmCtlInit}, 4'b0000);
  endtask

  task automatic t_wakeA;
    irqPinAN = 1'b0;
    tick(3);
    check("R6", "still asleep after 3 edges", en(), 4'b0000);
    tick(1);
    check("R6", "enables back at 4th edge", en(), 4'b0111);
    check("R6", "wake pulse & mode",
          {2'b0, wakeIrq, pinIrqMode}, 4'b0010);
    irqPinAN = 1'b1;
    tick(1);
    check("R6", "wake pulse one cycle", {3'b0, wakeIrq}, 4'b0000);
    tick(4);
  endtask

  task automatic t_glitch;
    enterSleep("R7");
    irqPinAN = 1'b0;
    tick(1);
    irqPinAN = 1'b1;
    tick(6);
    check("R7", "glitch ignored", en(), 4'b0000);
    check("R7", "no wake pulse", {3'b0, wakeIrq}, 4'b0000);
  endtask

  task automatic t_wakeB;
    irqPinBN = 1'b0;
    tick(3);
    check("R8", "still asleep after 3 edges", en(), 4'b0000);
    tick(1);
    check("R8", "pin B wakes", {wakeIrq, cpuClkEn, rngClkEn, wdtClkEn}, 4'b1111);
    irqPinBN = 1'b1;
    tick(4);
  endtask

  task automatic t_reject;
    dirBitA = 1'b1;
    sleepReq = 1'b1;
    tick(1);
    sleepReq = 1'b0;
    check("R4", "dirA blocks", en(), 4'b0111);
    check("R4", "flag set, no strobe", {2'b0, sleepRejected, nvmCtlInit}, 4'b0010);
    dirBitA = 1'b0; dirBitB = 1'b1;
    sleepReq = 1'b1;
    tick(1);
    sleepReq = 1'b0;
    check("R4", "dirB blocks", en(), 4'b0111);
    dirBitB = 1'b0;
    enterSleep("R4");
    check("R4", "flag cleared on accept", {3'b0, sleepRejected}, 4'b0000);
  endtask

  task automatic t_resetAsleep;
    rstN = 1'b0;
    tick(1);
    check("R9", "enables in reset", en(), 4'b0111);
    check("R9", "strobe & mode in reset", {2'b0, nvmCtlInit, pinIrqMode}, 4'b0010);
    rstN = 1'b1;
    tick(1);
    check("R9", "awake after reset", {nvmCtlInit, cpuClkEn, rngClkEn, wdtClkEn}, 4'b0111);
  endtask

  task automatic t_awakePins;
    irqPinAN = 1'b0; irqPinBN = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      check("R10", "no wake while awake", {wakeIrq, cpuClkEn, rngClkEn, wdtClkEn}, 4'b0111);
    end
    irqPinAN = 1'b1; irqPinBN = 1'b1;
    tick(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_entry();
    t_wakeA();
    t_glitch();
    t_wakeB();
    t_reject();
    t_resetAsleep();
    t_awakePins();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule